// File: doc/BRIEF.md
# Single-Channel Handshaked DMA Engine

This block is one DMA channel. Software programs a source address, a destination address, a 24-bit transfer cycle count and a control word through a small register port. Setting the enable bit starts the transfer. The engine then moves data one unit at a time over a simple request/acknowledge master port. Each unit is a read from the source address followed by a write to the destination address. After every unit, each address steps up, steps down or stays fixed, according to a 3-bit code for that side.

A transfer cycle is one unit in single mode or four units in burst mode. Before each cycle starts, the engine can wait for a peripheral request line on either side, and it pulses the matching grant line when the cycle ends. The cycle count can be read while the transfer runs and counts down by one per completed cycle, so software can work out how much data is still to move. The engine sets a finish or error status bit when it stops, and raises a maskable interrupt. Software walks any chain of buffers itself between completions.

Top module: `dmach_top`

## Requirements
- R1: After reset, all four registers read 0, `irq` is 0, `m_req` is 0 and `hs_gnt` is 0.
- R2: Register byte offsets on `reg_addr` are 0x0 source address, 0x4 destination address, 0x8 cycle count and 0xC control. Control bits are: 0 enable, 1 finish status, 2 finish interrupt enable, 3 burst, 4 error status, 5 error interrupt enable, 6 source bus select, 7 destination bus select, 10:8 source step code, 14:12 destination step code, 19:16 destination request line, 21:20 width, 27:24 source request line. All other bits read 0.
- R3: After each unit, a side's address changes by its step code. 000 and 100 hold the address. 001, 010 and 011 add 1, 2 and 4. 101, 110 and 111 subtract 1, 2 and 4. The source steps after its read and the destination steps after its write.
- R4: In burst mode a cycle is four units, so the per-cycle address step is 4, 8 or 16. In single mode a cycle is one unit.
- R5: The cycle count register decrements by one when each cycle's last write completes, and it can be read while the transfer runs.
- R6: When the count reaches zero, finish status sets and enable clears in the same clock.
- R7: Enabling with a count of 0 sets finish status and clears enable without any bus access.
- R8: Finish and error status clear only when software writes the control word with that bit at 0. Writing a 1 to a status bit never sets it.
- R9: `irq` = (finish status AND finish interrupt enable) OR (error status AND error interrupt enable).
- R10: When a side's request line field is nonzero, each cycle waits until `hs_req` at that index is high. When the cycle completes, `hs_gnt` at that index pulses for exactly one clock. A field of 0 means no wait and no grant.
- R11: An access acknowledged with `m_err` high sets error status, clears enable and stops the transfer. The address of the failed access does not step, and the count does not decrement.
- R12: If software clears enable mid-transfer, the engine stops issuing accesses within one clock. Finish status is not set and the count keeps its value.
- R13: `m_size` equals the width field (00 word, 01 half, 10 byte). `m_sys` equals the source bus select bit on reads and the destination bus select bit on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| m_req | output | 1 | Master access request, held until acknowledged |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Access byte address |
| m_size | output | 2 | Access width code |
| m_sys | output | 1 | Target bus: 1 system, 0 peripheral |
| m_wdata | output | 32 | Write data, low-aligned |
| m_rdata | input | 32 | Read data, low-aligned |
| m_ack | input | 1 | Access completion |
| m_err | input | 1 | Error response, qualified by m_ack |
| hs_req | input | 16 | Peripheral request lines (index 0 unused) |
| hs_grant | output | 16 | Peripheral grant pulses |
| irq | output | 1 | Interrupt |

## Verification
The bench goes after the stepping corner cases: a downward byte source feeding a held destination, and a burst of half-words counting down. A design that scaled the step per unit instead of per cycle, or that stepped a held side, would leave wrong final addresses and put the wrong byte in the fixed target. The count is sampled in the clock after the first burst cycle ends, which exposes a decrement per unit instead of per cycle. A zero count must finish with no bus traffic; a naive engine would underflow and run 2^24 cycles. Further tests cover:
- handshake waits where only one of two required request lines is high;
- an error on the second write, where an engine that stepped or counted on the failing access would show shifted addresses;
- abort during a streaming transfer;
- sticky status with write-1 having no effect.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int LINE_W = 4;
  localparam int LINES  = 1 << LINE_W;

  // register select from reg_addr[3:2]
  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  typedef struct packed {
    logic [3:0]        rsv_hi;
    logic [LINE_W-1:0] src_line;
    logic [1:0]        rsv_w;
    logic [1:0]        width;
    logic [LINE_W-1:0] dst_line;
    logic              rsv_d;
    logic [2:0]        dst_step;
    logic              rsv_s;
    logic [2:0]        src_step;
    logic              dst_sys;
    logic              src_sys;
    logic              err_ie;
    logic              err_sts;
    logic              burst;
    logic              fin_ie;
    logic              fin_sts;
    logic              en;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} eng_st_e;
endpackage

// File: rtl/dmach_step.sv
module dmach_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        code_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] mag;

  always_comb begin
    case (code_i[1:0])
      2'b01:   mag = ADDR_W'(1);
      2'b10:   mag = ADDR_W'(2);
      2'b11:   mag = ADDR_W'(4);
      default: mag = '0;
    endcase
    addr_o = code_i[2] ? (addr_i - mag) : (addr_i + mag);
  end
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              src_adv_i,
  input  logic [ADDR_W-1:0] src_nxt_i,
  input  logic              dst_adv_i,
  input  logic [ADDR_W-1:0] dst_nxt_i,
  input  logic              cnt_dec_i,
  input  logic              fin_i,
  input  logic              err_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output ctrl_t             ctrl_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  ctrl_t             ctrl_q, ctrl_d, wr_ctrl;
  logic              src_en, dst_en, cnt_en, ctrl_en;
  logic              sw_src, sw_dst, sw_cnt, sw_ctrl;

  assign sw_src  = reg_wr && (reg_addr[3:2] == SEL_SRC);
  assign sw_dst  = reg_wr && (reg_addr[3:2] == SEL_DST);
  assign sw_cnt  = reg_wr && (reg_addr[3:2] == SEL_CNT);
  assign sw_ctrl = reg_wr && (reg_addr[3:2] == SEL_CTRL);

  always_comb begin
    wr_ctrl         = ctrl_t'(reg_wdata);
    wr_ctrl.rsv_hi  = '0;
    wr_ctrl.rsv_w   = '0;
    wr_ctrl.rsv_d   = 1'b0;
    wr_ctrl.rsv_s   = 1'b0;
    wr_ctrl.fin_sts = ctrl_q.fin_sts & wr_ctrl.fin_sts;
    wr_ctrl.err_sts = ctrl_q.err_sts & wr_ctrl.err_sts;

    src_d = sw_src ? reg_wdata[ADDR_W-1:0] : src_nxt_i;
    dst_d = sw_dst ? reg_wdata[ADDR_W-1:0] : dst_nxt_i;
    cnt_d = sw_cnt ? reg_wdata[CNT_W-1:0] : (cnt_q - CNT_W'(1));
    src_en = sw_src | src_adv_i;
    dst_en = sw_dst | dst_adv_i;
    cnt_en = sw_cnt | cnt_dec_i;

    ctrl_d = sw_ctrl ? wr_ctrl : ctrl_q;
    if (fin_i) begin
      ctrl_d.fin_sts = 1'b1;
      ctrl_d.en      = 1'b0;
    end
    if (err_i) begin
      ctrl_d.err_sts = 1'b1;
      ctrl_d.en      = 1'b0;
    end
    ctrl_en = sw_ctrl | fin_i | err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (src_en)  src_q  <= src_d;
      if (dst_en)  dst_q  <= dst_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    case (reg_addr[3:2])
      SEL_SRC: reg_rdata = 32'(src_q);
      SEL_DST: reg_rdata = 32'(dst_q);
      SEL_CNT: reg_rdata = 32'(cnt_q);
      default: reg_rdata = 32'(ctrl_q);
    endcase
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign irq_o  = (ctrl_q.fin_sts & ctrl_q.fin_ie) | (ctrl_q.err_sts & ctrl_q.err_ie);

  // R5: without a software write the count only moves down by one
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != $past(cnt_q)) && !$past(sw_cnt)) |-> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R6: finish status appears together with enable dropping
  assert_fin_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.fin_sts) |-> $fell(ctrl_q.en));
  // R11: an error response leaves error status set and the channel stopped
  assert_err_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> (ctrl_q.err_sts && !ctrl_q.en));
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
  import dmach_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 24,
  parameter int BURST_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              burst_i,
  input  logic [LINE_W-1:0] src_line_i,
  input  logic [LINE_W-1:0] dst_line_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  output logic              m_req_o,
  output logic              m_we_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [DATA_W-1:0] m_wdata_o,
  input  logic [DATA_W-1:0] m_rdata_i,
  input  logic              m_ack_i,
  input  logic              m_err_i,
  input  logic [LINES-1:0]  hs_req_i,
  output logic [LINES-1:0]  hs_gnt_o,
  output logic              src_adv_o,
  output logic              dst_adv_o,
  output logic              cnt_dec_o,
  output logic              fin_o,
  output logic              err_o
);
  localparam int BEAT_W = $clog2(BURST_BEATS);

  eng_st_e           st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d, last_beat;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic [LINES-1:0]  gnt_q, gnt_d;
  logic              buf_en, src_ok, dst_ok;

  assign last_beat = burst_i ? BEAT_W'(BURST_BEATS - 1) : '0;
  assign src_ok    = (src_line_i == '0) || hs_req_i[src_line_i];
  assign dst_ok    = (dst_line_i == '0) || hs_req_i[dst_line_i];

  always_comb begin
    st_d      = st_q;
    beat_d    = beat_q;
    buf_d     = m_rdata_i;
    buf_en    = 1'b0;
    gnt_d     = '0;
    src_adv_o = 1'b0;
    dst_adv_o = 1'b0;
    cnt_dec_o = 1'b0;
    fin_o     = 1'b0;
    err_o     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en_i) begin
          if (cnt_i == '0) fin_o = 1'b1;
          else begin
            st_d   = ST_WAIT;
            beat_d = '0;
          end
        end
      end
      ST_WAIT: begin
        if (!en_i) st_d = ST_IDLE;
        else if (src_ok && dst_ok) st_d = ST_RD;
      end
      ST_RD: begin
        if (!en_i) st_d = ST_IDLE;
        else if (m_ack_i) begin
          if (m_err_i) begin
            err_o = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            buf_en    = 1'b1;
            src_adv_o = 1'b1;
            st_d      = ST_WR;
          end
        end
      end
      default: begin
        if (!en_i) st_d = ST_IDLE;
        else if (m_ack_i) begin
          if (m_err_i) begin
            err_o = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            dst_adv_o = 1'b1;
            if (beat_q == last_beat) begin
              cnt_dec_o = 1'b1;
              if (src_line_i != '0) gnt_d[src_line_i] = 1'b1;
              if (dst_line_i != '0) gnt_d[dst_line_i] = 1'b1;
              if (cnt_i == CNT_W'(1)) begin
                fin_o = 1'b1;
                st_d  = ST_IDLE;
              end else begin
                beat_d = '0;
                st_d   = ST_WAIT;
              end
            end else begin
              beat_d = beat_q + BEAT_W'(1);
              st_d   = ST_RD;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      buf_q  <= '0;
      gnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      gnt_q  <= gnt_d;
      if (buf_en) buf_q <= buf_d;
    end
  end

  assign m_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign m_we_o    = (st_q == ST_WR);
  assign m_addr_o  = (st_q == ST_WR) ? dst_addr_i : src_addr_i;
  assign m_wdata_o = buf_q;
  assign hs_gnt_o  = gnt_q;

  // R10: a grant never lasts longer than one clock
  assert_gnt_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gnt_o != '0) |=> (hs_gnt_o == '0));
  // R12: once enable falls, no request is presented on the next clock
  assert_abort_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_i) |=> !m_req_o);
  // R7: a zero count never starts a bus access
  assert_zero_noacc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (cnt_i == '0) && !m_req_o) |=> !m_req_o);
endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic              m_sys,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_ack,
  input  logic              m_err,
  input  logic [LINES-1:0]  hs_req,
  output logic [LINES-1:0]  hs_grant,
  output logic              irq
);
  localparam int SIDES = 2;

  logic rst_meta_q, rst_sync_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [ADDR_W-1:0] side_addr [SIDES];
  logic [ADDR_W-1:0] side_nxt  [SIDES];
  logic [2:0]        side_code [SIDES];
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  ctrl_t             ctrl;
  logic              src_adv, dst_adv, cnt_dec, fin, err;

  assign side_addr[0] = src_q;
  assign side_addr[1] = dst_q;
  assign side_code[0] = ctrl.src_step;
  assign side_code[1] = ctrl.dst_step;

  for (genvar s = 0; s < SIDES; s++) begin : g_step
    dmach_step #(.ADDR_W(ADDR_W)) u_step (
      .addr_i (side_addr[s]),
      .code_i (side_code[s]),
      .addr_o (side_nxt[s])
    );
  end

  dmach_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_adv_i (src_adv),
    .src_nxt_i (side_nxt[0]),
    .dst_adv_i (dst_adv),
    .dst_nxt_i (side_nxt[1]),
    .cnt_dec_i (cnt_dec),
    .fin_i     (fin),
    .err_i     (err),
    .src_o     (src_q),
    .dst_o     (dst_q),
    .cnt_o     (cnt_q),
    .ctrl_o    (ctrl),
    .irq_o     (irq)
  );

  dmach_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .en_i       (ctrl.en),
    .burst_i    (ctrl.burst),
    .src_line_i (ctrl.src_line),
    .dst_line_i (ctrl.dst_line),
    .cnt_i      (cnt_q),
    .src_addr_i (src_q),
    .dst_addr_i (dst_q),
    .m_req_o    (m_req),
    .m_we_o     (m_we),
    .m_addr_o   (m_addr),
    .m_wdata_o  (m_wdata),
    .m_rdata_i  (m_rdata),
    .m_ack_i    (m_ack),
    .m_err_i    (m_err),
    .hs_req_i   (hs_req),
    .hs_gnt_o   (hs_grant),
    .src_adv_o  (src_adv),
    .dst_adv_o  (dst_adv),
    .cnt_dec_o  (cnt_dec),
    .fin_o      (fin),
    .err_o      (err)
  );

  assign m_size = ctrl.width;
  assign m_sys  = m_we ? ctrl.dst_sys : ctrl.src_sys;
endmodule

// File: tb/dmach_top_test.sv
`timescale 1ns/1ps
module dmach_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        m_req, m_we, m_sys;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;
  logic        m_ack, m_err;
  logic [15:0] hs_req, hs_grant;
  logic        irq;

  always #2.5 clk = ~clk;

  dmach_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_size(m_size), .m_sys(m_sys), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err), .hs_req(hs_req),
    .hs_grant(hs_grant), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, side_bad = 0;
  int gnt_cnt [16];
  logic [7:0]  mem [1024];
  logic        inj_on = 1'b0;
  logic [31:0] inj_addr = '0;
  logic        side_chk = 1'b0;
  logic [1:0]  exp_size = '0;
  logic        exp_ssys = 1'b0, exp_dsys = 1'b0;
  logic        finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic en, fie, bst, eie, ssys, dsys,
      input logic [2:0] ss, ds, input logic [3:0] dl, input logic [1:0] w,
      input logic [3:0] sl);
    return {4'b0, sl, 2'b0, w, dl, 1'b0, ds, 1'b0, ss, dsys, ssys, eie, 1'b0, bst, fie, 1'b0, en};
  endfunction

  // bus responder: answers each request one negedge after it appears
  initial begin
    m_ack = 1'b0; m_err = 1'b0; m_rdata = '0;
    for (int i = 0; i < 16; i++) gnt_cnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 16; i++) if (hs_grant[i]) gnt_cnt[i]++;
      if (m_ack) begin
        m_ack = 1'b0; m_err = 1'b0;
      end else if (m_req) begin
        automatic int nb = (m_size == 2'b00) ? 4 : (m_size == 2'b01) ? 2 : 1;
        if (side_chk && (m_size != exp_size || m_sys != (m_we ? exp_dsys : exp_ssys)))
          side_bad++;
        if (m_we) begin
          for (int b = 0; b < nb; b++) mem[(m_addr + b) & 1023] = m_wdata[8*b +: 8];
          wr_cnt++;
        end else begin
          m_rdata = '0;
          for (int b = 0; b < nb; b++) m_rdata[8*b +: 8] = mem[(m_addr + b) & 1023];
          rd_cnt++;
        end
        m_err = inj_on && (m_addr == inj_addr);
        m_ack = 1'b1;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(4'hC, c);
      if (!c[0]) break;
    end
  endtask

  task automatic setup(input logic [31:0] s, d, c);
    wr(4'h0, s); wr(4'h4, d); wr(4'h8, c);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 irq/req/grant reset", {irq, m_req, hs_grant}, 32'h0);
  endtask

  task automatic t_word_copy();
    logic [31:0] v, c;
    int bad = 0, r0 = rd_cnt, w0 = wr_cnt;
    for (int i = 0; i < 12; i++) mem[12'h100 + i] = 8'(i * 7 + 3);
    setup(32'h100, 32'h200, 32'd3);
    c = ctl(1, 1, 0, 0, 0, 0, 3'b011, 3'b011, 0, 2'b00, 0);
    wr(4'hC, c);
    wait_idle();
    for (int i = 0; i < 12; i++) if (mem[12'h200 + i] !== mem[12'h100 + i]) bad++;
    chk("R3 word copy data", 32'(bad), 0);
    rd(4'h0, v); chk("R3 src after +4 x3", v, 32'h10C);
    rd(4'h4, v); chk("R3 dst after +4 x3", v, 32'h20C);
    rd(4'h8, v); chk("R6 count at zero", v, 0);
    rd(4'hC, v); chk("R2 R6 control readback", v, (c & ~32'h1) | 32'h2);
    chk("R9 finish irq", 32'(irq), 1);
    chk("R4 single mode accesses", 32'((rd_cnt - r0) + (wr_cnt - w0)), 6);
  endtask

  task automatic t_burst_residue();
    logic [31:0] v;
    int bad = 0, w0 = wr_cnt;
    for (int i = 0; i < 32; i++) mem[12'h140 + i] = 8'(i ^ 8'h5A);
    setup(32'h140, 32'h240, 32'd2);
    wr(4'hC, ctl(1, 0, 1, 0, 0, 0, 3'b011, 3'b011, 0, 2'b00, 0));
    wait (wr_cnt == w0 + 4);
    @(negedge clk);
    rd(4'h8, v); chk("R5 residue after first burst cycle", v, 1);
    wait_idle();
    for (int i = 0; i < 32; i++) if (mem[12'h240 + i] !== mem[12'h140 + i]) bad++;
    chk("R4 burst data", 32'(bad), 0);
    rd(4'h0, v); chk("R4 src after two bursts", v, 32'h160);
    rd(4'h4, v); chk("R4 dst after two bursts", v, 32'h260);
    chk("R4 burst write count", 32'(wr_cnt - w0), 8);
  endtask

  task automatic t_byte_down_hold();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) mem[12'h300 + i] = 8'hA0 + 8'(i);
    setup(32'h303, 32'h380, 32'd3);
    exp_size = 2'b10; exp_ssys = 1'b1; exp_dsys = 1'b0; side_bad = 0; side_chk = 1'b1;
    wr(4'hC, ctl(1, 0, 0, 0, 1, 0, 3'b101, 3'b000, 0, 2'b10, 0));
    wait_idle();
    side_chk = 1'b0;
    chk("R3 held dst last byte", 32'(mem[12'h380]), 32'hA1);
    rd(4'h0, v); chk("R3 src after -1 x3", v, 32'h300);
    rd(4'h4, v); chk("R3 held dst address", v, 32'h380);
    chk("R13 size/bus select", 32'(side_bad), 0);
  endtask

  task automatic t_half_burst_down();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) mem[12'h180 + i] = 8'h30 + 8'(i);
    setup(32'h180, 32'h2A0, 32'd1);
    exp_size = 2'b01; exp_ssys = 1'b0; exp_dsys = 1'b1; side_bad = 0; side_chk = 1'b1;
    wr(4'hC, ctl(1, 1, 1, 0, 0, 1, 3'b010, 3'b110, 0, 2'b01, 0));
    wait_idle();
    side_chk = 1'b0;
    rd(4'h4, v); chk("R4 dst after burst of -2", v, 32'h298);
    rd(4'h0, v); chk("R4 src after burst of +2", v, 32'h188);
    chk("R3 last half lands low", {mem[12'h29B], mem[12'h29A]}, {mem[12'h187], mem[12'h186]});
    chk("R13 half width select", 32'(side_bad), 0);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    wr(4'hC, ctl(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    rd(4'hC, v); chk("R8 finish cleared by writing 0", 32'(v[1]), 0);
    chk("R9 irq drops after clear", 32'(irq), 0);
    wr(4'hC, ctl(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0) | 32'h12);
    rd(4'hC, v); chk("R8 writing 1 does not set status", 32'(v[4:1] & 4'b1001), 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    mem[12'h100] = 8'h11;
    setup(32'h100, 32'h3C0, 32'd1);
    wr(4'hC, ctl(1, 0, 0, 0, 0, 0, 3'b011, 3'b011, 0, 2'b00, 0));
    wait_idle();
    rd(4'hC, v); chk("R9 finish set while masked", 32'(v[1]), 1);
    chk("R9 irq masked", 32'(irq), 0);
    wr(4'hC, ctl(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0) | 32'h2);
    chk("R9 irq after unmask", 32'(irq), 1);
    wr(4'hC, 32'h0);
  endtask

  task automatic t_zero_count();
    logic [31:0] v;
    int a0 = rd_cnt + wr_cnt;
    setup(32'h100, 32'h3E0, 32'd0);
    wr(4'hC, ctl(1, 1, 0, 0, 0, 0, 3'b011, 3'b011, 0, 2'b00, 0));
    repeat (4) @(negedge clk);
    rd(4'hC, v); chk("R7 zero count finishes, enable clear", 32'(v[1:0]), 32'h2);
    chk("R7 no accesses on zero count", 32'(rd_cnt + wr_cnt - a0), 0);
    wr(4'hC, 32'h0);
  endtask

  task automatic t_handshake();
    logic [31:0] v;
    int a0 = rd_cnt + wr_cnt;
    for (int i = 0; i < 16; i++) gnt_cnt[i] = 0;
    setup(32'h100, 32'h3A0, 32'd2);
    wr(4'hC, ctl(1, 0, 0, 0, 0, 0, 3'b011, 3'b011, 4'd5, 2'b00, 4'd3));
    repeat (20) @(negedge clk);
    chk("R10 waits with no request", 32'(rd_cnt + wr_cnt - a0), 0);
    hs_req[3] = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 waits for second side", 32'(rd_cnt + wr_cnt - a0), 0);
    hs_req[5] = 1'b1;
    wait_idle();
    hs_req = '0;
    rd(4'h8, v); chk("R10 transfer done after requests", v, 0);
    chk("R10 source grant pulses", 32'(gnt_cnt[3]), 2);
    chk("R10 dest grant pulses", 32'(gnt_cnt[5]), 2);
    chk("R10 no stray grants", 32'(gnt_cnt[0] + gnt_cnt[1] + gnt_cnt[7]), 0);
    wr(4'hC, 32'h0);
  endtask

  task automatic t_error();
    logic [31:0] v;
    inj_addr = 32'h224; inj_on = 1'b1;
    setup(32'h100, 32'h220, 32'd4);
    wr(4'hC, ctl(1, 0, 0, 1, 0, 0, 3'b011, 3'b011, 0, 2'b00, 0));
    wait_idle();
    inj_on = 1'b0;
    rd(4'hC, v); chk("R11 error set, finish clear, stopped", 32'(v[4:0]), 32'h10);
    chk("R11 error irq", 32'(irq), 1);
    rd(4'h8, v); chk("R11 count after one good cycle", v, 3);
    rd(4'h4, v); chk("R11 failed dst not stepped", v, 32'h224);
    rd(4'h0, v); chk("R11 src stepped for completed read", v, 32'h108);
    wr(4'hC, ctl(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
    chk("R8 error cleared by writing 0", 32'(irq), 0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    int a0 = rd_cnt;
    int a1;
    setup(32'h100, 32'h3F0, 32'd100);
    wr(4'hC, ctl(1, 1, 0, 0, 0, 0, 3'b000, 3'b000, 0, 2'b00, 0));
    wait (rd_cnt > a0 + 5);
    wr(4'hC, 32'h0);
    repeat (2) @(negedge clk);
    a1 = rd_cnt + wr_cnt;
    repeat (20) @(negedge clk);
    chk("R12 no accesses after abort", 32'(rd_cnt + wr_cnt - a1), 0);
    rd(4'hC, v); chk("R12 finish not set on abort", 32'(v[1:0]), 0);
    rd(4'h8, v);
    n_chk++;
    if (v == 0 || v >= 100) begin
      n_fail++;
      $display("FAIL R12 count kept actual %0d expected between 1 and 99", v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; hs_req = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_word_copy();
    t_burst_residue();
    t_byte_down_hold();
    t_half_burst_down();
    t_sticky();
    t_mask();
    t_zero_count();
    t_handshake();
    t_error();
    t_abort();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule